// File: doc/BRIEF.md
# Deferred-Ratio System Cycle Divider

This block produces the system cycle enable from the oscillator clock. The enable is a single-cycle pulse every 4, 8, 16 or 32 oscillator cycles. Software picks the ratio with a 2-bit field on a small write port. The field is write-only, and a value written there does not change the running ratio. It is held as a pending choice. The live divider takes the pending choice only when the power-mode controller brings the system back into active operation from a state in which the system clock was stopped: either the watch state or the subactive state.

While the mode input is anything other than active, the divider sits at zero and emits no pulses. Each time a new ratio is loaded, counting restarts, so the first period after a change is always full length. Entering the stop state wipes the pending choice back to the divide-by-4 code. Reset is synchronous and active high.

Top module: `sysclk_div_defer`

## Requirements
- R1: After reset the effective ratio is divide by 4 and the pending code is 00. The pulse output is low during reset. The first pulse comes on the 4th rising edge after reset is released.
- R2: Ratio codes are: 00 gives 4, 01 gives 8, 10 gives 16, 11 gives 32. In steady active mode the pulse is one cycle wide and repeats every N cycles.
- R3: A write is taken only when the write strobe is high and the address is 0x28. Data bits above bit 1 are ignored.
- R4: A write does not change the ratio currently running.
- R5: The pending code becomes effective at the first rising edge at which the mode input reads active (00) after it read watch (10).
- R6: The pending code also becomes effective at the first active edge after subactive (01).
- R7: The pending code is forced to 00 in every cycle the mode input reads stop (11).
- R8: While the mode input is not active, the pulse output is low and the divider is held at zero.
- R9: The edge that loads a ratio restarts the count. The first pulse after a load comes N edges after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data; bits 1:0 hold the ratio code |
| pmode | input | 2 | Power mode: 00 active, 01 subactive, 10 watch, 11 stop |
| cyc_en | output | 1 | One-cycle system cycle enable pulse |

## Verification
The only observable is when `cyc_en` pulses, so every internal error shows up as a wrong pulse spacing. A bad effective ratio shows up within one period: the gap between pulses is too short or too long. A pending code that was lost, or that was cleared when it should not have been, shows up one period after the next return to active: the first gap comes out at the wrong length. A divider that is not cleared on load shows up as a shortened first gap. A pulse that leaks out during a stopped mode shows up on the very next cycle.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;

    localparam int SEL_W     = 2;
    localparam int BASE_LOG2 = 2;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam logic [ADDR_W-1:0] SEL_ADDR = 8'h28;
    localparam int CNT_W     = BASE_LOG2 + (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'b00,
        PM_SUBACT = 2'b01,
        PM_WATCH  = 2'b10,
        PM_STOP   = 2'b11
    } pmode_e;

    typedef logic [SEL_W-1:0] divsel_t;
    typedef logic [CNT_W-1:0] divcnt_t;

    typedef struct packed {
        logic    load;
        divsel_t sel;
    } ratio_upd_t;

    function automatic divcnt_t terminal_count(divsel_t s);
        int r;
        r = (1 << (BASE_LOG2 + int'(s))) - 1;
        return r[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/sysdiv_regport.sv
module sysdiv_regport
    import sysdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  pmode_e            mode,
    output divsel_t           pend_o
);
    logic    hit;
    divsel_t pend_q;

    assign hit = wr_en && (wr_addr == SEL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (mode == PM_STOP) begin
            pend_q <= '0;
        end else if (hit) begin
            pend_q <= wr_data[SEL_W-1:0];
        end
    end

    assign pend_o = pend_q;

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_STOP) |=> (pend_q == '0));

    // R3
    pend_source_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != $past(pend_q)) |-> ($past(hit) || $past(mode) == PM_STOP));

endmodule

// File: rtl/sysdiv_apply.sv
module sysdiv_apply
    import sysdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pmode_e     mode,
    input  divsel_t    pend,
    output ratio_upd_t upd_o,
    output divsel_t    eff_o
);
    pmode_e  prev_q;
    divsel_t eff_q;
    logic    load;

    assign load = (mode == PM_ACTIVE) &&
                  ((prev_q == PM_WATCH) || (prev_q == PM_SUBACT));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= PM_ACTIVE;
            eff_q  <= '0;
        end else begin
            prev_q <= mode;
            if (load) begin
                eff_q <= pend;
            end
        end
    end

    assign upd_o.load = load;
    assign upd_o.sel  = pend;
    assign eff_o      = eff_q;

    // R4
    eff_change_chk: assert property (@(posedge clk) disable iff (rst)
        (eff_q != $past(eff_q)) |->
            ($past(mode) == PM_ACTIVE && $past(prev_q) != PM_ACTIVE
             && $past(prev_q) != PM_STOP));

endmodule

// File: rtl/sysdiv_counter.sv
module sysdiv_counter
    import sysdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pmode_e     mode,
    input  ratio_upd_t upd,
    input  divsel_t    eff,
    output logic       tick_o
);
    divcnt_t cnt_q;
    logic    tick_q;
    logic    hold;

    assign hold = (mode != PM_ACTIVE) || upd.load;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == terminal_count(eff)) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q && (mode == PM_ACTIVE);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != PM_ACTIVE) |=> (cnt_q == '0 && !tick_q));

    // R9
    reload_restart_chk: assert property (@(posedge clk) disable iff (rst)
        upd.load |=> (cnt_q == '0 && !tick_q));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

endmodule

// File: rtl/sysclk_div_defer.sv
module sysclk_div_defer
    import sysdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        pmode,
    output logic              cyc_en
);
    pmode_e     mode;
    divsel_t    pend;
    divsel_t    eff;
    ratio_upd_t upd;

    assign mode = pmode_e'(pmode);

    sysdiv_regport u_regport (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode    (mode),
        .pend_o  (pend)
    );

    sysdiv_apply u_apply (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .pend  (pend),
        .upd_o (upd),
        .eff_o (eff)
    );

    sysdiv_counter u_counter (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .upd    (upd),
        .eff    (eff),
        .tick_o (cyc_en)
    );

endmodule

// File: tb/sysclk_div_defer_tb.sv
`timescale 1ns/1ps
module sysclk_div_defer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] pmode = 2'b00;
    logic       cyc_en;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    sysclk_div_defer u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pmode   (pmode),
        .cyc_en  (cyc_en)
    );

    function automatic int ratio(int code);
        return 4 << code;
    endfunction

    task automatic check(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        pmode = m;
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d, logic en);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // counts negedges from now until the pulse is seen
    task automatic gap(string req, int exp);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!cyc_en && k < 200);
        check(req, k, exp);
    endtask

    task automatic wait_tick();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!cyc_en && k < 200);
    endtask

    task automatic quiet(string req, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(req, int'(cyc_en), 0);
        end
    endtask

    initial begin
        #400000;
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int cur;
        repeat (4) @(negedge clk);
        check("R1 pulse low in reset", int'(cyc_en), 0);
        rst = 1'b0;
        gap("R1 first pulse", 4);
        gap("R2 steady /4", 4);
        cur = 0;

        // watch route, sweep every code
        for (int s = 0; s < 4; s++) begin
            write_reg(8'h28, 8'(s), 1'b1);
            wait_tick();
            gap("R4 old ratio after write", ratio(cur));
            gap("R4 old ratio held", ratio(cur));
            set_mode(2'b10);
            quiet("R8 watch quiet", 3);
            set_mode(2'b00);
            gap("R5 R9 first period after watch", ratio(s) + 1);
            gap("R2 steady period", ratio(s));
            gap("R2 steady period again", ratio(s));
            cur = s;
        end

        // subactive route
        for (int s = 3; s >= 0; s--) begin
            set_mode(2'b01);
            write_reg(8'h28, 8'(s), 1'b1);
            quiet("R8 subactive quiet", 2);
            set_mode(2'b00);
            gap("R6 first period after subactive", ratio(s) + 1);
            gap("R2 steady after subactive", ratio(s));
            cur = s;
        end

        // decode: wrong address, strobe low, upper bits
        write_reg(8'h29, 8'h03, 1'b1);
        write_reg(8'h28, 8'h03, 1'b0);
        set_mode(2'b10);
        quiet("R8 watch quiet", 2);
        set_mode(2'b00);
        gap("R3 ignored writes keep /4", 5);
        write_reg(8'h28, 8'hFD, 1'b1);
        set_mode(2'b10);
        set_mode(2'b00);
        gap("R3 upper bits ignored gives /8", 9);
        gap("R3 steady /8", 8);

        // stop clears pending
        write_reg(8'h28, 8'h03, 1'b1);
        set_mode(2'b11);
        quiet("R8 stop quiet", 3);
        set_mode(2'b10);
        set_mode(2'b00);
        gap("R7 stop cleared pending", 5);
        gap("R7 steady /4", 4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule